// File: doc/BRIEF.md
# Timer Count-Enable Edge Selector

This block is the front end of one timer channel. It chooses the source that steps the channel's 16-bit up-counter and turns that source into single-cycle count enables in the system clock domain. The source can be the system clock itself, one of three divided clocks (divide by 4, 16 and 64), one of three external clock pins, or a cascade pulse from a neighbouring channel's wrap. A programmable edge rule selects rising, falling or both edges of the chosen source. The rule is forced to rising edge for the undivided clock and for the cascade input. In phase-counting mode the edge rule and the source are bypassed, and a step pulse from an external phase decoder drives the counter.

An 8-bit control word holds a counter-clear source field, the edge field and the source field. Software writes this word while the channel is stopped and can always read it back. A start input gates counting through a small run-control state machine with three states. HALT is the stopped state and is the only state that accepts writes. ARM lasts one cycle and lets the edge detector take in the new source level without counting. COUNT is the running state. The transitions are: HALT to ARM when start rises, ARM to COUNT when start is still high, ARM to HALT when start has dropped, and COUNT to HALT when start drops. The counter wraps from 0xFFFF to 0x0000 and raises a one-cycle wrap pulse, which can feed another channel's cascade input.

Top module: `tse_count_front`

## Requirements
- R1: After reset the control word reads 0x00, the count is 0x0000, and the count enable and wrap pulse are low.
- R2: A control write in the stopped state stores the full byte, and it reads back unchanged. Bits [7:5] are the clear-source field (stored only), bits [4:3] are the edge field, and bits [2:0] are the source field.
- R3: A control write made while the channel is arming or running is dropped, and the read value keeps its old contents.
- R4: While the channel is stopped or arming, the count enable stays low and the count holds its value.
- R5: Source codes are: 000 every system clock cycle, 001 clock/4, 010 clock/16, 011 clock/64, 100/101/110 external pins 0/1/2, 111 cascade input.
- R6: The edge field is 00 for rising, 01 for falling, and 10 or 11 for both edges. On a divided clock of ratio N, rising or falling gives one enable per N cycles, and both edges gives two.
- R7: External pins pass through a two-flop synchronizer. Each qualifying pin edge gives exactly one single-cycle enable, and each enable adds exactly one to the count.
- R8: With source 000 or 111, the edge field is ignored and counting acts as rising edge. Each cascade pulse gives exactly one count even when both-edge mode is set.
- R9: In phase-counting mode, each phase step pulse adds one count, whatever the edge and source fields hold.
- R10: On the enable that steps the count past 0xFFFF, the count becomes 0x0000 and the wrap pulse is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word read-back |
| run | input | 1 | Start bit; high lets the channel count |
| phase_mode | input | 1 | Selects phase-counting mode |
| phase_step | input | 1 | Single-cycle step pulse from the phase decoder |
| ext_pin | input | 3 | Asynchronous external clock pins |
| cascade_in | input | 1 | Wrap pulse from the neighbouring channel |
| cnt_en | output | 1 | Single-cycle count enable |
| count | output | 16 | Counter value |
| ovf | output | 1 | One-cycle wrap pulse |

## Verification
A control write and the rise of the start bit can arrive on the same clock edge. The bench drives both on one edge: it writes a clock/16 rising-edge word over a stored divide-by-1 setting and raises start together with it. It then judges the outcome from two things: the read-back value must be the new word, and the count rate must be one per 16 cycles rather than one per cycle. This shows that the write landed while the state was still HALT, and that the ARM cycle kept a level change from the source switch out of the count.

// File: rtl/tse_pkg.sv
package tse_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        RULE_RISE = 2'd0,
        RULE_FALL = 2'd1,
        RULE_BOTH = 2'd2
    } edge_rule_e;

    typedef struct packed {
        logic [2:0] clr_src;
        logic [1:0] edge_sel;
        logic [2:0] clk_sel;
    } tmr_ctl_t;

    localparam logic [2:0] SRC_DIV1    = 3'd0;
    localparam logic [2:0] SRC_DIV4    = 3'd1;
    localparam logic [2:0] SRC_DIV16   = 3'd2;
    localparam logic [2:0] SRC_DIV64   = 3'd3;
    localparam logic [2:0] SRC_CASCADE = 3'd7;
    localparam int         EXT_BASE    = 4;

endpackage

// File: rtl/tse_prescaler.sv
module tse_prescaler #(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] div_lvl
);
    localparam int TAP4  = 1;
    localparam int TAP16 = 3;
    localparam int TAP64 = 5;

    logic [DIV_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    assign div_lvl = {phase_q[TAP64], phase_q[TAP16], phase_q[TAP4]};
endmodule

// File: rtl/tse_sync2.sv
module tse_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/tse_edge_det.sv
module tse_edge_det
    import tse_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  edge_rule_e rule,
    output logic       hit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        unique case (rule)
            RULE_RISE: hit = lvl & ~prev_q;
            RULE_FALL: hit = ~lvl & prev_q;
            RULE_BOTH: hit = lvl ^ prev_q;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tse_count_front.sv
module tse_count_front
    import tse_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_EXT = 3,
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    input  logic             run,
    input  logic             phase_mode,
    input  logic             phase_step,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic             cascade_in,
    output logic             cnt_en,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    tmr_ctl_t    ctl_q;
    run_state_e  st_q, st_d;
    logic [2:0]  div_lvl;
    logic [N_EXT-1:0] ext_sync;
    logic        ext_pick;
    logic        src_lvl;
    logic        src_every;
    logic        force_rise;
    edge_rule_e  rule;
    logic        edge_hit;
    logic        step_hit;
    logic        cnt_en_q;
    logic [CNT_W-1:0] count_q;
    logic        ovf_q;

    tse_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_lvl (div_lvl)
    );

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext_sync
        tse_sync2 u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (ext_pin[g]),
            .q     (ext_sync[g])
        );
    end

    always_comb begin
        ext_pick = 1'b0;
        for (int i = 0; i < N_EXT; i++) begin
            if (ctl_q.clk_sel == 3'(EXT_BASE + i)) ext_pick = ext_sync[i];
        end
    end

    always_comb begin
        src_lvl    = 1'b0;
        src_every  = 1'b0;
        force_rise = 1'b0;
        unique case (ctl_q.clk_sel)
            SRC_DIV1: begin
                src_every  = 1'b1;
                force_rise = 1'b1;
            end
            SRC_DIV4:    src_lvl = div_lvl[0];
            SRC_DIV16:   src_lvl = div_lvl[1];
            SRC_DIV64:   src_lvl = div_lvl[2];
            SRC_CASCADE: begin
                src_lvl    = cascade_in;
                force_rise = 1'b1;
            end
            default:     src_lvl = ext_pick;
        endcase
    end

    always_comb begin
        if (force_rise)               rule = RULE_RISE;
        else if (ctl_q.edge_sel[1])   rule = RULE_BOTH;
        else if (ctl_q.edge_sel[0])   rule = RULE_FALL;
        else                          rule = RULE_RISE;
    end

    tse_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (src_lvl),
        .rule  (rule),
        .hit   (edge_hit)
    );

    assign step_hit = phase_mode ? phase_step : (src_every | edge_hit);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT:  if (run)  st_d = ST_ARM;
            ST_ARM:   st_d = run ? ST_COUNT : ST_HALT;
            ST_COUNT: if (!run) st_d = ST_HALT;
            default:  st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            cnt_en_q <= 1'b0;
            count_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (ctl_wr && st_q == ST_HALT) ctl_q <= tmr_ctl_t'(ctl_wdata);
            cnt_en_q <= (st_q == ST_COUNT) && step_hit;
            ovf_q    <= cnt_en_q && (count_q == CNT_TOP);
            if (cnt_en_q) count_q <= count_q + 1'b1;
        end
    end

    assign ctl_rdata = ctl_q;
    assign cnt_en    = cnt_en_q;
    assign count     = count_q;
    assign ovf       = ovf_q;
endmodule

// File: rtl/tse_count_front_chk.sv
module tse_count_front_chk
    import tse_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input run_state_e       st_q,
    input logic [7:0]       ctl_rdata,
    input logic             cnt_en,
    input logic [CNT_W-1:0] count,
    input logic             ovf
);
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_COUNT) |=> !cnt_en); // R4
    AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_HALT) |=> $stable(ctl_rdata)); // R3
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> (count == CNT_W'($past(count) + 1'b1))); // R7
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count)); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0)); // R10
    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf); // R10
    AST_ARM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |=> (st_q != ST_COUNT)); // R4
endmodule

bind tse_count_front tse_count_front_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .ctl_rdata (ctl_rdata),
    .cnt_en    (cnt_en),
    .count     (count),
    .ovf       (ovf)
);

// File: tb/tse_count_front_tb.sv
module tse_count_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        run = 1'b0;
    logic        phase_mode = 1'b0;
    logic        phase_step = 1'b0;
    logic [2:0]  ext_pin = '0;
    logic        cascade_in = 1'b0;
    logic        cnt_en;
    logic [15:0] count;
    logic        ovf;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    tse_count_front dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .run        (run),
        .phase_mode (phase_mode),
        .phase_step (phase_step),
        .ext_pin    (ext_pin),
        .cascade_in (cascade_in),
        .cnt_en     (cnt_en),
        .count      (count),
        .ovf        (ovf)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            checks   = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic start_run();
        @(negedge clk); run = 1'b1; tick(6);
    endtask

    task automatic stop_run();
        @(negedge clk); run = 1'b0; tick(4);
    endtask

    task automatic window(input int n, output int delta);
        logic [15:0] c0;
        c0 = count;
        tick(n);
        delta = int'(16'(count - c0));
    endtask

    task automatic t_reset();
        chk("R1 ctl", ctl_rdata, 0);
        chk("R1 count", count, 0);
        chk("R1 cnt_en", cnt_en, 0);
        chk("R1 ovf", ovf, 0);
    endtask

    task automatic t_regfile();
        write_ctl(8'hA5); tick(1);
        chk("R2 readback A5", ctl_rdata, 8'hA5);
        write_ctl(8'h5A); tick(1);
        chk("R2 readback 5A", ctl_rdata, 8'h5A);
    endtask

    task automatic t_div_rates();
        int d;
        for (int s = 1; s <= 3; s++) begin
            for (int e = 0; e < 4; e++) begin
                int ratio = (s == 1) ? 4 : (s == 2) ? 16 : 64;
                int exp = (128 / ratio) * ((e >= 2) ? 2 : 1);
                write_ctl(8'(e << 3) | 8'(s));
                start_run();
                window(128, d);
                chk($sformatf("R5/R6 src%0d edge%0d", s, e), d, exp);
                stop_run();
            end
        end
        write_ctl(8'b000_10_000);
        start_run();
        window(32, d);
        chk("R5/R8 undivided both-edge", d, 32);
        stop_run();
    endtask

    task automatic t_halt();
        int d;
        int en_seen = 0;
        logic [15:0] c0;
        write_ctl(8'h00);
        c0 = count;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cnt_en) en_seen++;
        end
        d = int'(16'(count - c0));
        chk("R4 halted count delta", d, 0);
        chk("R4 halted enables", en_seen, 0);
    endtask

    task automatic t_wr_running();
        write_ctl(8'b000_00_001);
        start_run();
        write_ctl(8'hFF); tick(1);
        chk("R3 write while running dropped", ctl_rdata, 8'h01);
        stop_run();
        write_ctl(8'hFF); tick(1);
        chk("R3 write after stop taken", ctl_rdata, 8'hFF);
    endtask

    task automatic t_ext();
        for (int p = 0; p < 3; p++) begin
            for (int e = 0; e < 3; e++) begin
                logic [15:0] c0;
                int d;
                int en_cnt = 0;
                write_ctl(8'(e << 3) | 8'(4 + p));
                start_run();
                c0 = count;
                for (int k = 0; k < 3; k++) begin
                    ext_pin[p] = 1'b1;
                    for (int i = 0; i < 6; i++) begin @(negedge clk); if (cnt_en) en_cnt++; end
                    ext_pin[p] = 1'b0;
                    for (int i = 0; i < 6; i++) begin @(negedge clk); if (cnt_en) en_cnt++; end
                end
                for (int i = 0; i < 8; i++) begin @(negedge clk); if (cnt_en) en_cnt++; end
                d = int'(16'(count - c0));
                chk($sformatf("R7 pin%0d edge%0d count", p, e), d, (e == 2) ? 6 : 3);
                chk($sformatf("R7 pin%0d edge%0d enables", p, e), en_cnt, (e == 2) ? 6 : 3);
                stop_run();
            end
        end
    endtask

    task automatic t_cascade();
        for (int e = 1; e < 3; e++) begin
            logic [15:0] c0;
            int d;
            write_ctl(8'(e << 3) | 8'd7);
            start_run();
            c0 = count;
            for (int k = 0; k < 4; k++) begin
                cascade_in = 1'b1; tick(1);
                cascade_in = 1'b0; tick(5);
            end
            tick(4);
            d = int'(16'(count - c0));
            chk($sformatf("R8 cascade edge%0d", e), d, 4);
            stop_run();
        end
    endtask

    task automatic t_phase();
        logic [15:0] c0;
        int d;
        write_ctl(8'b000_10_001);
        phase_mode = 1'b1;
        start_run();
        c0 = count;
        for (int k = 0; k < 5; k++) begin
            phase_step = 1'b1; tick(1);
            phase_step = 1'b0; tick(11);
        end
        tick(4);
        d = int'(16'(count - c0));
        chk("R9 phase steps only", d, 5);
        stop_run();
        phase_mode = 1'b0;
    endtask

    task automatic t_concurrent();
        int d;
        write_ctl(8'h00);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = 8'b000_00_010; run = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        tick(6);
        chk("R2 write with start taken", ctl_rdata, 8'h02);
        window(64, d);
        chk("R6 rate after write with start", d, 4);
        stop_run();
    endtask

    task automatic t_overflow();
        int waited = 0;
        write_ctl(8'h00);
        @(negedge clk); run = 1'b1;
        while (!ovf && waited < 70000) begin
            @(negedge clk);
            waited++;
        end
        chk("R10 wrap seen", ovf, 1);
        chk("R10 count at wrap", count, 0);
        @(negedge clk);
        chk("R10 wrap one cycle", ovf, 0);
        chk("R10 count after wrap", count, 1);
        stop_run();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_regfile();
        t_div_rates();
        t_halt();
        t_wr_running();
        t_ext();
        t_cascade();
        t_phase();
        t_concurrent();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule